// File: doc/BRIEF.md
# Selectable Frequency Output Generator

The block drives a single clock-like output whose rate is picked by a 3-bit select code. Four fast rates are divided from a crystal edge tick: 32768, 16384, 8192 and 4096 Hz. Two slow rates come from an AC mains edge tick: the line frequency itself and 1 Hz. The 1 Hz rate falls back to the crystal whenever the AC source is flagged as not qualified. Two further codes hold the output constantly low or constantly high.

Both tick inputs are single-cycle enables in the system clock domain. `xtal_tick_i` pulses on every edge of the crystal, which is 65536 times a second. `ac_tick_i` pulses on every edge of the mains waveform, which is 100 or 120 times a second. The output is a 50% duty square wave built by toggling a register on counted ticks.

A battery-active flag combined with a battery-off control bit forces the output low. Any change of select code clears every divider, so the new rate starts from a low level and a full half period.

Top module: `freq_out_sel`

## Requirements
- R1: Codes 0 to 3 give a square wave that toggles once every 2^code crystal ticks: code 0 toggles on every tick, code 3 on every eighth tick.
- R2: Code 4 gives the line frequency: the output toggles on every AC tick.
- R3: Code 5 with `ac_ok_i`=1 toggles once every AC_HALF_50 AC ticks (default 50) when `line_60_i`=0, and once every AC_HALF_60 AC ticks (default 60) when `line_60_i`=1.
- R4: Code 5 with `ac_ok_i`=0 toggles once every XTAL_HALF_1HZ crystal ticks.
- R5: Code 6 holds the output low and code 7 holds it high.
- R6: When `bat_act_i`=1 and `bat_off_i`=1 the output is low. If either of them is 0, the output follows the select code.
- R7: On the clock edge after `sel_i` changes, all dividers restart from zero. Divided codes (0 to 5) then show low, and the first toggle comes one full half period later.
- R8: After reset the select register holds code 0 and all dividers are zero, so the output is low.
- R9: With no tick, a stable select and stable control inputs, the output does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xtal_tick_i | input | 1 | One-cycle pulse per crystal edge |
| ac_tick_i | input | 1 | One-cycle pulse per mains edge |
| ac_ok_i | input | 1 | AC source qualified |
| line_60_i | input | 1 | 1: 60 Hz mains, 0: 50 Hz mains |
| bat_act_i | input | 1 | Battery backup active |
| bat_off_i | input | 1 | Disable the output while on battery |
| sel_i | input | 3 | Rate select code |
| fout_o | output | 1 | Frequency output |

## Verification
Some properties are checked on every cycle: the battery gating, the constant-high code, the low level right after a select change, a toggle on every crystal tick under code 0, and a held output when no tick arrives. The exact division ratios can only be shown by the bench's scenarios, which count ticks into each code and compare the level. The same holds for the 50/60 selection, the fallback from AC to crystal and the proof that counting restarts after a select change.

// File: rtl/fo_pkg.sv
package fo_pkg;
  typedef enum logic [2:0] {
    FS_DIV1 = 3'd0,
    FS_DIV2 = 3'd1,
    FS_DIV4 = 3'd2,
    FS_DIV8 = 3'd3,
    FS_LINE = 3'd4,
    FS_ONE  = 3'd5,
    FS_LOW  = 3'd6,
    FS_HIGH = 3'd7
  } fo_sel_e;

  localparam int unsigned NTAP = 4;
endpackage

// File: rtl/fo_bin_div.sv
module fo_bin_div #(
  parameter int unsigned NTAP = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            tick_i,
  output logic [NTAP-1:0] tap_o
);
  logic [NTAP-1:0] cnt_q;

  // bit k toggles every 2^k ticks
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign tap_o = cnt_q;
endmodule

// File: rtl/fo_half_div.sv
module fo_half_div #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         tick_i,
  input  logic [W-1:0] limit_i,
  output logic         q_o
);
  logic [W-1:0] cnt_q;
  logic         q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      q_q   <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      q_q   <= 1'b0;
    end else if (tick_i) begin
      // >= so a limit lowered mid-count still wraps
      if (cnt_q >= limit_i) begin
        cnt_q <= '0;
        q_q   <= ~q_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/freq_out_sel.sv
module freq_out_sel #(
  parameter int unsigned XTAL_HALF_1HZ = 32768,
  parameter int unsigned AC_HALF_50    = 50,
  parameter int unsigned AC_HALF_60    = 60
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       xtal_tick_i,
  input  logic       ac_tick_i,
  input  logic       ac_ok_i,
  input  logic       line_60_i,
  input  logic       bat_act_i,
  input  logic       bat_off_i,
  input  logic [2:0] sel_i,
  output logic       fout_o
);
  import fo_pkg::*;

  localparam int unsigned XW = $clog2(XTAL_HALF_1HZ + 1);
  localparam int unsigned AW = $clog2(AC_HALF_60 + 1);

  logic [2:0]      sel_q;
  logic            clr;
  logic [NTAP-1:0] xtap;
  logic            line_sq, ac_1hz, xt_1hz, sel_out;
  logic [AW-1:0]   ac_lim;

  // select register: mux uses sel_q so clear and switch land on one edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= FS_DIV1;
    else         sel_q <= sel_i;
  end

  assign clr    = (sel_i != sel_q);
  assign ac_lim = line_60_i ? AW'(AC_HALF_60 - 1) : AW'(AC_HALF_50 - 1);

  fo_bin_div #(.NTAP(NTAP)) u_xbin (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(clr),
    .tick_i(xtal_tick_i), .tap_o(xtap)
  );

  fo_half_div #(.W(1)) u_line (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(clr),
    .tick_i(ac_tick_i), .limit_i(1'b0), .q_o(line_sq)
  );

  fo_half_div #(.W(AW)) u_ac1 (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(clr),
    .tick_i(ac_tick_i), .limit_i(ac_lim), .q_o(ac_1hz)
  );

  fo_half_div #(.W(XW)) u_xt1 (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(clr),
    .tick_i(xtal_tick_i), .limit_i(XW'(XTAL_HALF_1HZ - 1)), .q_o(xt_1hz)
  );

  always_comb begin
    case (sel_q)
      FS_DIV1: sel_out = xtap[0];
      FS_DIV2: sel_out = xtap[1];
      FS_DIV4: sel_out = xtap[2];
      FS_DIV8: sel_out = xtap[3];
      FS_LINE: sel_out = line_sq;
      FS_ONE:  sel_out = ac_ok_i ? ac_1hz : xt_1hz;
      FS_LOW:  sel_out = 1'b0;
      default: sel_out = 1'b1;
    endcase
  end

  assign fout_o = sel_out & ~(bat_act_i & bat_off_i);
endmodule

// File: rtl/freq_out_sel_chk.sv
module freq_out_sel_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       xtal_tick_i,
  input logic       ac_tick_i,
  input logic       ac_ok_i,
  input logic       bat_act_i,
  input logic       bat_off_i,
  input logic [2:0] sel_q,
  input logic       fout_o
);
  logic dis;
  assign dis = bat_act_i & bat_off_i;

  // R6
  a_r6_bat_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis |-> !fout_o);

  // R5
  a_r5_const_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q == 3'd7 && !dis) |-> fout_o);

  // R7
  a_r7_restart_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && sel_q != $past(sel_q) && sel_q < 3'd6) |-> !fout_o);

  // R1
  a_r1_div1_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(xtal_tick_i) && sel_q == 3'd0 && $past(sel_q) == 3'd0
     && !dis && !$past(dis)) |-> (fout_o != $past(fout_o)));

  // R9
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(xtal_tick_i) && !$past(ac_tick_i) && $stable(sel_q)
     && $stable(dis) && $stable(ac_ok_i)) |-> $stable(fout_o));
endmodule

bind freq_out_sel freq_out_sel_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .xtal_tick_i(xtal_tick_i),
  .ac_tick_i  (ac_tick_i),
  .ac_ok_i    (ac_ok_i),
  .bat_act_i  (bat_act_i),
  .bat_off_i  (bat_off_i),
  .sel_q      (sel_q),
  .fout_o     (fout_o)
);

// File: tb/freq_out_sel_tb.sv
module freq_out_sel_tb;
  localparam int unsigned XH = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic xt = 1'b0, act = 1'b0, ok = 1'b1, l60 = 1'b0, bat = 1'b0, boff = 1'b0;
  logic [2:0] sel = 3'd0;
  logic fout;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  freq_out_sel #(.XTAL_HALF_1HZ(XH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .xtal_tick_i(xt), .ac_tick_i(act),
    .ac_ok_i(ok), .line_60_i(l60), .bat_act_i(bat), .bat_off_i(boff),
    .sel_i(sel), .fout_o(fout)
  );

  typedef struct packed {
    logic [2:0]  sel;
    logic        ok;
    logic        l60;
    int unsigned n;
  } vec_t;

  localparam vec_t VECS [18] = '{
    '{3'd0, 1'b1, 1'b0, 1},   '{3'd0, 1'b1, 1'b0, 6},
    '{3'd1, 1'b1, 1'b0, 3},   '{3'd1, 1'b1, 1'b0, 6},
    '{3'd2, 1'b1, 1'b0, 5},   '{3'd3, 1'b1, 1'b0, 8},
    '{3'd3, 1'b1, 1'b0, 15},  '{3'd4, 1'b1, 1'b0, 3},
    '{3'd4, 1'b1, 1'b0, 4},   '{3'd5, 1'b1, 1'b0, 50},
    '{3'd5, 1'b1, 1'b0, 100}, '{3'd5, 1'b1, 1'b1, 50},
    '{3'd5, 1'b1, 1'b1, 61},  '{3'd5, 1'b0, 1'b0, 9},
    '{3'd5, 1'b0, 1'b0, 17},  '{3'd5, 1'b0, 1'b1, 7},
    '{3'd6, 1'b1, 1'b0, 5},   '{3'd7, 1'b1, 1'b0, 5}
  };

  // model from the requirements
  function automatic logic model(vec_t v);
    case (v.sel)
      3'd0, 3'd1, 3'd2, 3'd3: return logic'((v.n >> v.sel) & 1);
      3'd4: return logic'(v.n & 1);
      3'd5: if (v.ok) return logic'((v.n / (v.l60 ? 60 : 50)) & 1);
            else      return logic'((v.n / XH) & 1);
      3'd6: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic bit uses_ac(vec_t v);
    return (v.sel == 3'd4) || (v.sel == 3'd5 && v.ok);
  endfunction

  task automatic check(string req, logic act_v, logic exp_v);
    checks++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act_v, exp_v);
    end
  endtask

  task automatic pulse(bit use_ac, int unsigned n);
    if (n == 0) return;
    if (use_ac) act = 1'b1; else xt = 1'b1;
    repeat (n) @(negedge clk);
    act = 1'b0; xt = 1'b0;
  endtask

  task automatic go_sel(logic [2:0] s);
    sel = 3'd6;
    @(negedge clk);
    sel = s;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset", fout, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 after release", fout, 1'b0);

    // R1 R2 R3 R4 R5 table
    foreach (VECS[i]) begin
      ok  = VECS[i].ok;
      l60 = VECS[i].l60;
      go_sel(VECS[i].sel);
      pulse(uses_ac(VECS[i]), VECS[i].n);
      case (VECS[i].sel)
        3'd0, 3'd1, 3'd2, 3'd3: check("R1 crystal divide", fout, model(VECS[i]));
        3'd4: check("R2 line", fout, model(VECS[i]));
        3'd5: if (VECS[i].ok) check("R3 ac 1hz", fout, model(VECS[i]));
              else            check("R4 crystal 1hz", fout, model(VECS[i]));
        default: check("R5 constant", fout, model(VECS[i]));
      endcase
    end

    // R6 battery gating
    ok = 1'b1;
    go_sel(3'd7);
    bat = 1'b1; boff = 1'b1; @(negedge clk);
    check("R6 gated", fout, 1'b0);
    bat = 1'b1; boff = 1'b0; @(negedge clk);
    check("R6 bat only", fout, 1'b1);
    bat = 1'b0; boff = 1'b1; @(negedge clk);
    check("R6 off bit only", fout, 1'b1);
    boff = 1'b0;

    // R7 restart on direct select change
    go_sel(3'd0);
    pulse(1'b0, 3);
    check("R7 pre", fout, 1'b1);
    sel = 3'd1; @(negedge clk);
    check("R7 low after change", fout, 1'b0);
    pulse(1'b0, 1);
    check("R7 restart count1", fout, 1'b0);
    pulse(1'b0, 1);
    check("R7 restart count2", fout, 1'b1);

    // R9 hold without ticks; ticks of the other source ignored
    go_sel(3'd2);
    pulse(1'b0, 4);
    check("R9 set", fout, 1'b1);
    repeat (10) @(negedge clk);
    check("R9 hold", fout, 1'b1);
    pulse(1'b1, 7);
    check("R9 ac ticks ignored", fout, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule